// File: doc/BRIEF.md
# Serial-Product Cellular Neural Network Cell

This block is a single processing element of a synchronous digital cellular neural network. Every value it handles is a 5-bit sign-magnitude fraction: a sign bit and a 4-bit magnitude, covering -15/15 to +15/15 in steps of 1/15, which gives 31 levels. Between cells, a value travels as a time stream plus a sign. The stream is high for the first |v| slots of a 15-slot window.

During one window the cell forms nine products at the same time. Eight products come from neighbouring cells and one comes from the cell's own stored output. Each weight magnitude is spread evenly across the window as a pulse pattern and ANDed with the incoming stream. The product sign is the XOR of the two signs. A signed counter adds +1 or -1 for every product pulse, which gives the net input.

At the end of the window the net passes through a selectable activation function: a hard limiter, or a threshold-logic ramp with slope 1, an adjustable threshold and saturation. The result is stored, then streamed back out for the neighbours during the next window. A load path lets an external value be written into the cell, and this also restarts the window.

Top module: `cnn_cell_serial`

## Requirements
- R1: `stream_o` is high exactly while `slot_o` is less than the stored magnitude `val_mag_o`, and `sgn_o` equals the stored sign `val_sgn_o`. Sign bit 1 means negative.
- R2: Each cycle with `en_i` high and `load_i` low advances `slot_o` by one. From 14 it wraps to 0. With both `en_i` and `load_i` low, `slot_o` and the stored value hold. After reset, `slot_o` is 0 and the stored value is +0.
- R3: A stream of magnitude x meeting a weight of magnitude w (`wgt_mag_i[4*i+3:4*i]`, sign `wgt_sgn_i[i]`) yields floor((x*w+7)/15) product pulses over one window. The product is negative when the stream sign XOR the weight sign is 1.
- R4: The net input is the signed sum of all nine products' pulse counts in the window. It spans -135 to +135 without wrapping.
- R5: With `act_sel_i`=0 (hard limiter), the result is +15 when net >= 0 and -15 otherwise.
- R6: With `act_sel_i`=1 (threshold logic), the result is net minus the threshold, saturated to the range -15..+15. The threshold is given in sign-magnitude as `thr_sgn_i`/`thr_mag_i`.
- R7: `load_i` high stores `load_sgn_i`/`load_mag_i` at the next edge and sets `slot_o` to 0. It takes priority over a window end in the same cycle.
- R8: A stored magnitude of 0 always carries sign 0, whether it came from a load or from a computed result.
- R9: Tap 4 (the fifth) uses the cell's own stored value. External neighbour k drives tap k for k<4 and tap k+1 for k>=4.
- R10: The stored value changes only at the edge that completes slot 14 with `en_i` high, or on a load. The new value is the one streamed during the following window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance one time slot |
| load_i | input | 1 | Store external value, restart window |
| load_mag_i | input | 4 | External value magnitude |
| load_sgn_i | input | 1 | External value sign (1 = negative) |
| nbr_strm_i | input | 8 | Neighbour time streams |
| nbr_sgn_i | input | 8 | Neighbour signs |
| wgt_mag_i | input | 36 | Nine weight magnitudes, tap i in bits 4i+3..4i |
| wgt_sgn_i | input | 9 | Nine weight signs |
| act_sel_i | input | 1 | 0 = hard limiter, 1 = threshold logic |
| thr_mag_i | input | 4 | Threshold magnitude |
| thr_sgn_i | input | 1 | Threshold sign |
| slot_o | output | 4 | Current slot in the window, 0..14 |
| stream_o | output | 1 | Own value as a time stream |
| sgn_o | output | 1 | Own value sign for neighbours |
| val_mag_o | output | 4 | Stored value magnitude |
| val_sgn_o | output | 1 | Stored value sign |

## Verification
A corrupted pulse pattern or counter shows up as a wrong stored value at the first window end after the fault: 15 enabled cycles later at most. It then reaches the stream output during the following window. A wrong slot counter is visible at once on `slot_o` and, in the same cycle, on `stream_o`. Because the cell's own output feeds back into tap 4, a single wrong result keeps reappearing in every later window that uses the self weight. The bench recomputes each window's net input from the stream and weight magnitudes by closed formula and compares every output on every clock.

// File: rtl/cnn_cell_pkg.sv
package cnn_cell_pkg;

  typedef enum logic {
    ACT_HARD = 1'b0,
    ACT_RAMP = 1'b1
  } act_mode_e;

endpackage

// File: rtl/cnn_slot_ctrl.sv
module cnn_slot_ctrl #(
  parameter int SLOTS  = 15,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              restart_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              first_o,
  output logic              last_o
);

  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] STEP     = SLOT_W'(1);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    slot_d = slot_q;
    if (restart_i) begin
      slot_d = '0;
    end else if (en_i) begin
      slot_d = (slot_q == LAST_IDX) ? '0 : slot_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_d;
    end
  end

  assign slot_o  = slot_q;
  assign first_o = (slot_q == '0);
  assign last_o  = (slot_q == LAST_IDX);

endmodule

// File: rtl/cnn_wgt_coder.sv
module cnn_wgt_coder #(
  parameter int MAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             first_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             pulse_o
);

  localparam int SLOTS = (2 ** MAG_W) - 1;
  localparam logic [MAG_W:0] FULL = (MAG_W + 1)'(SLOTS);
  localparam logic [MAG_W-1:0] HALF = MAG_W'(SLOTS / 2);

  logic [MAG_W-1:0] phase_q;
  logic [MAG_W-1:0] phase_d;
  logic [MAG_W-1:0] phase_cur;
  logic [MAG_W:0]   phase_sum;
  logic [MAG_W:0]   phase_rem;

  always_comb begin
    phase_cur = first_i ? HALF : phase_q;
    phase_sum = {1'b0, phase_cur} + {1'b0, mag_i};
    pulse_o   = (phase_sum >= FULL);
    phase_rem = pulse_o ? (phase_sum - FULL) : phase_sum;
    phase_d   = en_i ? phase_rem[MAG_W-1:0] : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/cnn_activation.sv
module cnn_activation
  import cnn_cell_pkg::*;
#(
  parameter int MAG_W = 4,
  parameter int ACC_W = 9
) (
  input  logic signed [ACC_W-1:0] net_i,
  input  act_mode_e               mode_i,
  input  logic                    thr_neg_i,
  input  logic [MAG_W-1:0]        thr_mag_i,
  output logic                    res_neg_o,
  output logic [MAG_W-1:0]        res_mag_o
);

  localparam int EXT_W = ACC_W + 1;
  localparam logic signed [EXT_W-1:0] TOP_V = EXT_W'((2 ** MAG_W) - 1);
  localparam logic [MAG_W-1:0] TOP_M = MAG_W'((2 ** MAG_W) - 1);

  logic signed [EXT_W-1:0] thr_s;
  logic signed [EXT_W-1:0] net_x;
  logic signed [EXT_W-1:0] diff;
  logic signed [EXT_W-1:0] diff_abs;

  always_comb begin
    thr_s = EXT_W'(thr_mag_i);
    if (thr_neg_i) begin
      thr_s = -thr_s;
    end
    net_x    = {net_i[ACC_W-1], net_i};
    diff     = net_x - thr_s;
    diff_abs = diff[EXT_W-1] ? -diff : diff;

    if (mode_i == ACT_HARD) begin
      res_neg_o = net_i[ACC_W-1];
      res_mag_o = TOP_M;
    end else if (diff > TOP_V) begin
      res_neg_o = 1'b0;
      res_mag_o = TOP_M;
    end else if (diff < -TOP_V) begin
      res_neg_o = 1'b1;
      res_mag_o = TOP_M;
    end else begin
      res_neg_o = diff[EXT_W-1];
      res_mag_o = diff_abs[MAG_W-1:0];
    end
  end

endmodule

// File: rtl/cnn_state_reg.sv
module cnn_state_reg #(
  parameter int MAG_W  = 4,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              load_neg_i,
  input  logic [MAG_W-1:0]  load_mag_i,
  input  logic              upd_i,
  input  logic              res_neg_i,
  input  logic [MAG_W-1:0]  res_mag_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [MAG_W-1:0]  mag_o,
  output logic              neg_o,
  output logic              stream_o
);

  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic [MAG_W-1:0] mag_d;
  logic             neg_d;
  logic             wr_en;

  always_comb begin
    wr_en = load_i | upd_i;
    mag_d = load_i ? load_mag_i : res_mag_i;
    neg_d = (load_i ? load_neg_i : res_neg_i) & (mag_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else if (wr_en) begin
      mag_q <= mag_d;
      neg_q <= neg_d;
    end
  end

  assign mag_o    = mag_q;
  assign neg_o    = neg_q;
  assign stream_o = (int'(slot_i) < int'(mag_q));

endmodule

// File: rtl/cnn_cell_serial.sv
module cnn_cell_serial
  import cnn_cell_pkg::*;
#(
  parameter int MAG_W    = 4,
  parameter int NTAPS    = 9,
  parameter int SELF_TAP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic                     load_i,
  input  logic [MAG_W-1:0]         load_mag_i,
  input  logic                     load_sgn_i,
  input  logic [NTAPS-2:0]         nbr_strm_i,
  input  logic [NTAPS-2:0]         nbr_sgn_i,
  input  logic [NTAPS*MAG_W-1:0]   wgt_mag_i,
  input  logic [NTAPS-1:0]         wgt_sgn_i,
  input  logic                     act_sel_i,
  input  logic [MAG_W-1:0]         thr_mag_i,
  input  logic                     thr_sgn_i,
  output logic [$clog2((2**MAG_W)-1)-1:0] slot_o,
  output logic                     stream_o,
  output logic                     sgn_o,
  output logic [MAG_W-1:0]         val_mag_o,
  output logic                     val_sgn_o
);

  localparam int SLOTS  = (2 ** MAG_W) - 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ACC_W  = $clog2(NTAPS * SLOTS + 1) + 1;
  localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic                    first_slot;
  logic                    last_slot;
  logic                    upd;
  logic [NTAPS-1:0]        tap_strm;
  logic [NTAPS-1:0]        tap_sgn;
  logic [NTAPS-1:0]        wpulse;
  logic                    own_strm;
  logic signed [ACC_W-1:0] contrib;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] acc_nx;
  logic                    res_neg;
  logic [MAG_W-1:0]        res_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  cnn_slot_ctrl #(
    .SLOTS (SLOTS),
    .SLOT_W(SLOT_W)
  ) u_slot (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_i     (en_i),
    .restart_i(load_i),
    .slot_o   (slot_o),
    .first_o  (first_slot),
    .last_o   (last_slot)
  );

  for (genvar gi = 0; gi < NTAPS; gi++) begin : g_tap
    if (gi == SELF_TAP) begin : g_self
      assign tap_strm[gi] = own_strm;
      assign tap_sgn[gi]  = val_sgn_o;
    end else if (gi < SELF_TAP) begin : g_lo
      assign tap_strm[gi] = nbr_strm_i[gi];
      assign tap_sgn[gi]  = nbr_sgn_i[gi];
    end else begin : g_hi
      assign tap_strm[gi] = nbr_strm_i[gi-1];
      assign tap_sgn[gi]  = nbr_sgn_i[gi-1];
    end

    cnn_wgt_coder #(
      .MAG_W(MAG_W)
    ) u_coder (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .en_i   (en_i),
      .first_i(first_slot),
      .mag_i  (wgt_mag_i[gi*MAG_W +: MAG_W]),
      .pulse_o(wpulse[gi])
    );
  end

  always_comb begin
    contrib = '0;
    for (int i = 0; i < NTAPS; i++) begin
      if (tap_strm[i] && wpulse[i]) begin
        if (tap_sgn[i] ^ wgt_sgn_i[i]) begin
          contrib = contrib - ONE;
        end else begin
          contrib = contrib + ONE;
        end
      end
    end
  end

  always_comb begin
    acc_nx = first_slot ? contrib : (acc_q + contrib);
    acc_d  = acc_q;
    if (load_i) begin
      acc_d = '0;
    end else if (en_i) begin
      acc_d = acc_nx;
    end
    upd = en_i & last_slot & ~load_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  cnn_activation #(
    .MAG_W(MAG_W),
    .ACC_W(ACC_W)
  ) u_act (
    .net_i    (acc_nx),
    .mode_i   (act_mode_e'(act_sel_i)),
    .thr_neg_i(thr_sgn_i),
    .thr_mag_i(thr_mag_i),
    .res_neg_o(res_neg),
    .res_mag_o(res_mag)
  );

  cnn_state_reg #(
    .MAG_W (MAG_W),
    .SLOT_W(SLOT_W)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (load_i),
    .load_neg_i(load_sgn_i),
    .load_mag_i(load_mag_i),
    .upd_i     (upd),
    .res_neg_i (res_neg),
    .res_mag_i (res_mag),
    .slot_i    (slot_o),
    .mag_o     (val_mag_o),
    .neg_o     (val_sgn_o),
    .stream_o  (own_strm)
  );

  assign stream_o = own_strm;
  assign sgn_o    = val_sgn_o;

endmodule

// File: rtl/cnn_cell_serial_chk.sv
module cnn_cell_serial_chk #(
  parameter int MAG_W  = 4,
  parameter int NTAPS  = 9,
  parameter int SLOT_W = 4,
  parameter int ACC_W  = 9
) (
  input logic                    clk,
  input logic                    rst_int_n,
  input logic                    en_i,
  input logic                    load_i,
  input logic [MAG_W-1:0]        load_mag_i,
  input logic                    act_sel_i,
  input logic [SLOT_W-1:0]       slot_o,
  input logic [MAG_W-1:0]        val_mag_o,
  input logic                    val_sgn_o,
  input logic signed [ACC_W-1:0] acc_q
);

  localparam int SLOTS = (2 ** MAG_W) - 1;
  localparam logic [MAG_W-1:0] TOP_M = MAG_W'(SLOTS);

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_i && !load_i && int'(slot_o) == SLOTS - 1) |=> (slot_o == '0)); // R2

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_i && !load_i && int'(slot_o) < SLOTS - 1) |=> (int'(slot_o) == int'($past(slot_o)) + 1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!en_i && !load_i) |=> ($stable(slot_o) && $stable(val_mag_o) && $stable(val_sgn_o))); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_o != '0) |-> (int'(acc_q) <= NTAPS * int'(slot_o) && int'(acc_q) >= -(NTAPS * int'(slot_o)))); // R4

  AST_HARD_FULL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_i && !load_i && int'(slot_o) == SLOTS - 1 && !act_sel_i) |=> (val_mag_o == TOP_M)); // R5

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_i |=> (val_mag_o == $past(load_mag_i) && slot_o == '0)); // R7

  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (val_mag_o == '0) |-> !val_sgn_o); // R8

  AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!load_i && !(en_i && int'(slot_o) == SLOTS - 1)) |=> ($stable(val_mag_o) && $stable(val_sgn_o))); // R10

endmodule

bind cnn_cell_serial cnn_cell_serial_chk #(
  .MAG_W (MAG_W),
  .NTAPS (NTAPS),
  .SLOT_W(SLOT_W),
  .ACC_W (ACC_W)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .en_i      (en_i),
  .load_i    (load_i),
  .load_mag_i(load_mag_i),
  .act_sel_i (act_sel_i),
  .slot_o    (slot_o),
  .val_mag_o (val_mag_o),
  .val_sgn_o (val_sgn_o),
  .acc_q     (acc_q)
);

// File: tb/cnn_cell_serial_bench.sv
`timescale 1ns/1ps
module cnn_cell_serial_bench;

  localparam int MW = 4;
  localparam int NT = 9;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            en_i;
  logic            load_i;
  logic [MW-1:0]   load_mag_i;
  logic            load_sgn_i;
  logic [NT-2:0]   nbr_strm_i;
  logic [NT-2:0]   nbr_sgn_i;
  logic [NT*MW-1:0] wgt_mag_i;
  logic [NT-1:0]   wgt_sgn_i;
  logic            act_sel_i;
  logic [MW-1:0]   thr_mag_i;
  logic            thr_sgn_i;
  logic [3:0]      slot_o;
  logic            stream_o;
  logic            sgn_o;
  logic [MW-1:0]   val_mag_o;
  logic            val_sgn_o;

  int  nbr_mag [NT-1];
  bit  nbr_neg [NT-1];
  int  w_mag   [NT];
  bit  w_neg   [NT];

  int  m_slot;
  int  m_mag;
  bit  m_neg;
  int  n_vec;
  int  n_bad;
  string cur_req;

  always #2 clk = ~clk;

  cnn_cell_serial u_cnn_cell_serial (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .load_i    (load_i),
    .load_mag_i(load_mag_i),
    .load_sgn_i(load_sgn_i),
    .nbr_strm_i(nbr_strm_i),
    .nbr_sgn_i (nbr_sgn_i),
    .wgt_mag_i (wgt_mag_i),
    .wgt_sgn_i (wgt_sgn_i),
    .act_sel_i (act_sel_i),
    .thr_mag_i (thr_mag_i),
    .thr_sgn_i (thr_sgn_i),
    .slot_o    (slot_o),
    .stream_o  (stream_o),
    .sgn_o     (sgn_o),
    .val_mag_o (val_mag_o),
    .val_sgn_o (val_sgn_o)
  );

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      wgt_mag_i[i*MW +: MW] = MW'(w_mag[i]);
      wgt_sgn_i[i]          = w_neg[i];
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int window_net();
    int net = 0;
    for (int i = 0; i < NT; i++) begin
      int x;
      bit xs;
      int p;
      if (i == 4) begin x = m_mag; xs = m_neg; end
      else if (i < 4) begin x = nbr_mag[i]; xs = nbr_neg[i]; end
      else begin x = nbr_mag[i-1]; xs = nbr_neg[i-1]; end
      p = (x * w_mag[i] + 7) / 15;
      net += (xs ^ w_neg[i]) ? -p : p;
    end
    return net;
  endfunction

  task automatic cycle(input bit en, input bit ld);
    en_i   = en;
    load_i = ld;
    for (int k = 0; k < NT-1; k++) begin
      nbr_strm_i[k] = (m_slot < nbr_mag[k]);
      nbr_sgn_i[k]  = nbr_neg[k];
    end
    if (ld) begin
      m_mag  = int'(load_mag_i);
      m_neg  = load_sgn_i && (load_mag_i != 0);
      m_slot = 0;
    end else if (en) begin
      if (m_slot == 14) begin
        int net = window_net();
        if (!act_sel_i) begin
          m_mag = 15;
          m_neg = (net < 0);
        end else begin
          int d = net - (thr_sgn_i ? -int'(thr_mag_i) : int'(thr_mag_i));
          if (d > 15) d = 15;
          if (d < -15) d = -15;
          m_neg = (d < 0);
          m_mag = (d < 0) ? -d : d;
        end
        m_slot = 0;
      end else begin
        m_slot++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check("R2", "slot", int'(slot_o), m_slot);
    check(cur_req, "value magnitude", int'(val_mag_o), m_mag);
    check(cur_req, "value sign", int'(val_sgn_o), int'(m_neg));
    check("R1", "stream", int'(stream_o), int'(m_slot < m_mag));
    check("R1", "stream sign", int'(sgn_o), int'(m_neg));
  endtask

  task automatic win(input bit gaps);
    for (int c = 0; c < 15; c++) begin
      if (gaps && (c % 4 == 2)) cycle(1'b0, 1'b0);
      cycle(1'b1, 1'b0);
    end
  endtask

  task automatic do_load(input int mag, input bit neg);
    load_mag_i = MW'(mag);
    load_sgn_i = neg;
    cycle(1'b0, 1'b1);
    load_i = 1'b0;
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < NT-1; k++) begin nbr_mag[k] = 0; nbr_neg[k] = 0; end
    for (int i = 0; i < NT; i++) begin w_mag[i] = 0; w_neg[i] = 0; end
  endtask

  task automatic expect_val(input string req, input int mag, input bit neg);
    check(req, "explicit magnitude", int'(val_mag_o), mag);
    check(req, "explicit sign", int'(val_sgn_o), int'(neg));
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    m_slot = 0; m_mag = 0; m_neg = 0;
    cur_req = "R2";
    rst_n = 1'b0; en_i = 0; load_i = 0; load_mag_i = 0; load_sgn_i = 0;
    nbr_strm_i = '0; nbr_sgn_i = '0; act_sel_i = 1; thr_mag_i = 0; thr_sgn_i = 0;
    clear_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cycle(1'b0, 1'b0);
    check("R2", "reset slot", int'(slot_o), 0);
    expect_val("R2", 0, 0);

    // R7 load
    cur_req = "R7";
    do_load(9, 0);
    expect_val("R7", 9, 0);

    // R3 products: x=8,w=5 -> 3 on neighbour 0
    cur_req = "R3";
    nbr_mag[0] = 8; w_mag[0] = 5;
    win(0);
    expect_val("R3", 3, 0);
    // x=11,w=6 negative weight on neighbour 7 (tap 8) -> -4
    clear_cfg();
    nbr_mag[7] = 11; w_mag[8] = 6; w_neg[8] = 1;
    win(1);
    expect_val("R3", 4, 1);

    // R9 self feedback
    cur_req = "R9";
    clear_cfg();
    do_load(10, 0);
    w_mag[4] = 15;
    win(0);
    expect_val("R9", 10, 0);
    w_neg[4] = 1;
    win(0);
    expect_val("R9", 10, 1);
    win(0);
    expect_val("R9", 10, 0);
    // neighbour 4 lands on tap 5, not on tap 4
    clear_cfg();
    do_load(0, 0);
    nbr_mag[4] = 15; w_mag[5] = 15;
    win(0);
    expect_val("R9", 15, 0);
    clear_cfg();
    do_load(0, 0);
    nbr_mag[4] = 15; w_mag[4] = 15;
    win(0);
    expect_val("R9", 0, 0);

    // R5 hard limiter
    cur_req = "R5";
    act_sel_i = 0;
    clear_cfg();
    win(0);
    expect_val("R5", 15, 0);
    nbr_mag[2] = 3; w_mag[2] = 5; w_neg[2] = 1;
    win(1);
    expect_val("R5", 15, 1);

    // R4 and R6 saturation at the extremes
    cur_req = "R4";
    act_sel_i = 1;
    do_load(15, 0);
    for (int k = 0; k < NT-1; k++) nbr_mag[k] = 15;
    for (int i = 0; i < NT; i++) begin w_mag[i] = 15; w_neg[i] = 0; end
    win(0);
    expect_val("R4", 15, 0);
    for (int i = 0; i < NT; i++) w_neg[i] = 1;
    win(0);
    expect_val("R6", 15, 1);
    cur_req = "R6";
    clear_cfg();
    thr_sgn_i = 1; thr_mag_i = 15;
    win(0);
    expect_val("R6", 15, 0);
    thr_sgn_i = 0; thr_mag_i = 15;
    win(0);
    expect_val("R6", 15, 1);

    // R8 zero normalisation
    cur_req = "R8";
    clear_cfg();
    nbr_mag[0] = 8; w_mag[0] = 5; thr_mag_i = 3; thr_sgn_i = 0;
    win(0);
    expect_val("R8", 0, 0);
    thr_mag_i = 5;
    win(0);
    expect_val("R6", 2, 1);
    do_load(0, 1);
    expect_val("R8", 0, 0);

    // R7 load mid-window and at the window end
    cur_req = "R7";
    thr_mag_i = 0;
    repeat (5) cycle(1'b1, 1'b0);
    do_load(12, 1);
    check("R7", "slot after load", int'(slot_o), 0);
    expect_val("R7", 12, 1);
    repeat (14) cycle(1'b1, 1'b0);
    load_mag_i = 4'd6; load_sgn_i = 1'b0;
    cycle(1'b1, 1'b1);
    load_i = 1'b0;
    expect_val("R7", 6, 0);

    // R10 and R2: windows with idle gaps, varied configurations
    cur_req = "R10";
    for (int r = 0; r < 60; r++) begin
      for (int k = 0; k < NT-1; k++) begin
        nbr_mag[k] = int'($urandom % 16);
        nbr_neg[k] = bit'($urandom % 2);
      end
      for (int i = 0; i < NT; i++) begin
        w_mag[i] = int'($urandom % 16);
        w_neg[i] = bit'($urandom % 2);
      end
      act_sel_i = logic'($urandom % 2);
      thr_mag_i = MW'($urandom % 16);
      thr_sgn_i = logic'($urandom % 2);
      cur_req = (r % 2 == 0) ? "R10" : "R4";
      win(r % 3 == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule